// File: doc/BRIEF.md
# Floating-Point Load Execution Unit

This unit carries out one floating-point load instruction at a time. It takes a 32-bit instruction word and the value of the integer base register. It decodes the destination register, the source register and the access width, and forms the effective address. It then checks that the instruction is legal and that the address is aligned. If both checks pass, it sends exactly one read request to a simple memory port.

When the memory answers, the unit writes the loaded value to a FLEN-wide floating-point register write port. A value narrower than FLEN is NaN-boxed: every bit above its width is set to one and the loaded bits are left unchanged. In the same cycle the unit raises a pulse that marks the floating-point state as dirty.

An illegal encoding or a misaligned address raises an exception code instead. In that case there is no memory request and no register write. The number of cycles the unit takes never depends on the loaded data.

Top module: `fp_load_unit`

## Requirements
- R1: The destination index is taken from instruction bits [11:7] and is presented on `fpr_idx_o` with the write. The base index is taken from bits [19:15] and is driven on `base_idx_o` in the same cycle as the instruction.
- R2: The effective address is `base_val_i` plus the sign-extended 12-bit immediate in bits [31:20]. It appears on `mem_addr_o` in the cycle after the instruction is accepted, together with `mem_req_o`.
- R3: funct3 (bits [14:12]) selects the width: 001 is 2 bytes, 010 is 4 bytes and 011 is 8 bytes. `mem_size_o` carries log2 of the byte count (1, 2 or 3).
- R4: Each legal, aligned instruction produces exactly one single-cycle `mem_req_o` pulse.
- R5: An address that is not a multiple of the access size raises `exc_valid_o` with `exc_code_o` = 4, one cycle after acceptance. No request and no write follow.
- R6: Each of the following raises `exc_valid_o` with `exc_code_o` = 2 and no request: an opcode (bits [6:0]) other than 0000111, funct3 000 (byte width), funct3 100 to 111, or funct3 011 when FLEN < 64. The illegal check takes priority over the alignment check.
- R7: A 2-byte load writes `mem_rdata_i[15:0]` unchanged into the low 16 bits, with all higher bits set to one.
- R8: With FLEN = 64, a 4-byte load writes `mem_rdata_i[31:0]` unchanged into the low word, NaN payloads included, with an upper word of 0xFFFFFFFF. The upper bits of the read data are ignored.
- R9: An 8-byte load writes all 64 bits of `mem_rdata_i` unchanged.
- R10: `fpr_we_o` and `fs_dirty_o` pulse together for one cycle, exactly one cycle after `mem_rvalid_i` is sampled, whatever the data value.
- R11: `ready_o` is low from the cycle after acceptance until the write cycle. While the unit waits for the response, no write and no further request occur.
- R12: After reset, `ready_o` is high and `mem_req_o`, `fpr_we_o`, `fs_dirty_o` and `exc_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid_i | input | 1 | Instruction offered (taken when ready_o is high) |
| issue_insn_i | input | 32 | Instruction word |
| base_val_i | input | XLEN | Integer base register value |
| base_idx_o | output | 5 | Decoded base register index |
| ready_o | output | 1 | Unit idle, can accept an instruction |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | XLEN | Read address |
| mem_size_o | output | 2 | log2 of bytes to read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | FLEN | Read data, right-aligned |
| fpr_we_o | output | 1 | FP register write enable |
| fpr_idx_o | output | 5 | FP destination index |
| fpr_wdata_o | output | FLEN | FP write data, NaN-boxed |
| fs_dirty_o | output | 1 | FP state dirty pulse |
| exc_valid_o | output | 1 | Exception pulse |
| exc_code_o | output | 4 | Exception cause (2 illegal, 4 misaligned) |

## Verification
The base index is combinational and is checked in the issue cycle. The request, its address and size, and any exception are due one cycle after the instruction is accepted. The bench samples these at the falling edge that follows the accepting edge. The write and the dirty pulse are due one cycle after `mem_rvalid_i` is sampled, so the bench raises the response at a falling edge after a random delay and checks at the next falling edge. At every falling edge in between, it confirms that no request or write is present.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
    localparam logic [6:0] OPC_FLOAD = 7'b0000111;
    localparam logic [3:0] EXC_ILLEGAL = 4'd2;
    localparam logic [3:0] EXC_LD_MISALIGN = 4'd4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } fpl_state_e;
endpackage

// File: rtl/fpl_decode.sv
module fpl_decode #(
    parameter int XLEN = 32,
    parameter int FLEN = 64
) (
    input  logic [31:0]     insn_i,
    input  logic [XLEN-1:0] base_i,
    output logic [4:0]      base_idx_o,
    output logic [4:0]      dest_idx_o,
    output logic [XLEN-1:0] addr_o,
    output logic [1:0]      size_o,
    output logic            illegal_o,
    output logic            misaligned_o
);
    import fpl_pkg::*;

    localparam int IMM_W = 12;

    logic [IMM_W-1:0] imm;
    logic [2:0]       funct3;
    logic             width_ok;

    assign imm        = insn_i[31:20];
    assign funct3     = insn_i[14:12];
    assign base_idx_o = insn_i[19:15];
    assign dest_idx_o = insn_i[11:7];
    assign addr_o     = base_i + {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign size_o     = funct3[1:0];

    always_comb begin
        case (funct3)
            3'b001, 3'b010: width_ok = 1'b1;
            3'b011:         width_ok = (FLEN >= 64);
            default:        width_ok = 1'b0;
        endcase
        illegal_o = (insn_i[6:0] != OPC_FLOAD) || !width_ok;
        case (size_o)
            2'd1:    misaligned_o = addr_o[0];
            2'd2:    misaligned_o = |addr_o[1:0];
            2'd3:    misaligned_o = |addr_o[2:0];
            default: misaligned_o = 1'b0;
        endcase
        if (illegal_o) misaligned_o = 1'b0;
    end
endmodule

// File: rtl/fpl_nanbox.sv
module fpl_nanbox #(
    parameter int FLEN = 64
) (
    input  logic [1:0]      size_i,
    input  logic [FLEN-1:0] raw_i,
    output logic [FLEN-1:0] boxed_o
);
    int unsigned nbits;

    always_comb begin
        nbits = 32'd8 << size_i;
        for (int i = 0; i < FLEN; i++) begin
            boxed_o[i] = (i < int'(nbits)) ? raw_i[i] : 1'b1;
        end
    end
endmodule

// File: rtl/fp_load_unit.sv
module fp_load_unit #(
    parameter int XLEN = 32,
    parameter int FLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid_i,
    input  logic [31:0]     issue_insn_i,
    input  logic [XLEN-1:0] base_val_i,
    output logic [4:0]      base_idx_o,
    output logic            ready_o,
    output logic            mem_req_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [1:0]      mem_size_o,
    input  logic            mem_rvalid_i,
    input  logic [FLEN-1:0] mem_rdata_i,
    output logic            fpr_we_o,
    output logic [4:0]      fpr_idx_o,
    output logic [FLEN-1:0] fpr_wdata_o,
    output logic            fs_dirty_o,
    output logic            exc_valid_o,
    output logic [3:0]      exc_code_o
);
    import fpl_pkg::*;

    typedef struct packed {
        fpl_state_e      st;
        logic            req;
        logic [XLEN-1:0] addr;
        logic [1:0]      size;
        logic [4:0]      rd;
        logic            we;
        logic [FLEN-1:0] wdata;
        logic            exc;
        logic [3:0]      code;
    } regs_t;

    regs_t r_d, r_q;

    logic [4:0]      dec_rd;
    logic [XLEN-1:0] dec_addr;
    logic [1:0]      dec_size;
    logic            dec_illegal, dec_misaligned;
    logic [FLEN-1:0] boxed;

    fpl_decode #(.XLEN(XLEN), .FLEN(FLEN)) decode_i (
        .insn_i       (issue_insn_i),
        .base_i       (base_val_i),
        .base_idx_o   (base_idx_o),
        .dest_idx_o   (dec_rd),
        .addr_o       (dec_addr),
        .size_o       (dec_size),
        .illegal_o    (dec_illegal),
        .misaligned_o (dec_misaligned)
    );

    fpl_nanbox #(.FLEN(FLEN)) nanbox_i (
        .size_i  (r_q.size),
        .raw_i   (mem_rdata_i),
        .boxed_o (boxed)
    );

    always_comb begin
        r_d     = r_q;
        r_d.req = 1'b0;
        r_d.we  = 1'b0;
        r_d.exc = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (issue_valid_i) begin
                    if (dec_illegal) begin
                        r_d.exc  = 1'b1;
                        r_d.code = EXC_ILLEGAL;
                    end else if (dec_misaligned) begin
                        r_d.exc  = 1'b1;
                        r_d.code = EXC_LD_MISALIGN;
                    end else begin
                        r_d.req  = 1'b1;
                        r_d.addr = dec_addr;
                        r_d.size = dec_size;
                        r_d.rd   = dec_rd;
                        r_d.st   = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    r_d.we    = 1'b1;
                    r_d.wdata = boxed;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ready_o     = (r_q.st == ST_IDLE);
    assign mem_req_o   = r_q.req;
    assign mem_addr_o  = r_q.addr;
    assign mem_size_o  = r_q.size;
    assign fpr_we_o    = r_q.we;
    assign fpr_idx_o   = r_q.rd;
    assign fpr_wdata_o = r_q.wdata;
    assign fs_dirty_o  = r_q.we;
    assign exc_valid_o = r_q.exc;
    assign exc_code_o  = r_q.code;

    p_single_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    p_exc_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |-> (!mem_req_o && !fpr_we_o));

    p_req_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ((mem_addr_o[2:0] & ((3'd1 << mem_size_o) - 3'd1)) == 3'd0));

    p_dirty_with_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fpr_we_o |-> fs_dirty_o);

    p_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !ready_o);

    p_write_after_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && mem_rvalid_i) |=> (fpr_we_o && ready_o));

    generate
        if (FLEN > 32) begin : g_box_chk
            p_box_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (fpr_we_o && mem_size_o == 2'd2) |-> (&fpr_wdata_o[FLEN-1:32]));
        end
    endgenerate
endmodule

// File: tb/fp_load_unit_tb_top.sv
module fp_load_unit_tb_top;
    localparam int XLEN = 32;
    localparam int FLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_valid_i = 1'b0;
    logic [31:0]     issue_insn_i = '0;
    logic [XLEN-1:0] base_val_i = '0;
    logic [4:0]      base_idx_o;
    logic            ready_o, mem_req_o, mem_rvalid_i = 1'b0;
    logic [XLEN-1:0] mem_addr_o;
    logic [1:0]      mem_size_o;
    logic [FLEN-1:0] mem_rdata_i = '0;
    logic            fpr_we_o, fs_dirty_o, exc_valid_o;
    logic [4:0]      fpr_idx_o;
    logic [FLEN-1:0] fpr_wdata_o;
    logic [3:0]      exc_code_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fp_load_unit #(.XLEN(XLEN), .FLEN(FLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid_i(issue_valid_i),
        .issue_insn_i(issue_insn_i), .base_val_i(base_val_i),
        .base_idx_o(base_idx_o), .ready_o(ready_o), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .fpr_we_o(fpr_we_o), .fpr_idx_o(fpr_idx_o), .fpr_wdata_o(fpr_wdata_o),
        .fs_dirty_o(fs_dirty_o), .exc_valid_o(exc_valid_o), .exc_code_o(exc_code_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [11:0] imm, input logic [4:0] rs1,
                                       input logic [2:0] f3, input logic [4:0] rd,
                                       input logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    function automatic logic [63:0] box(input logic [1:0] sz, input logic [63:0] raw);
        logic [63:0] v;
        v = raw;
        if (sz == 2'd1) v[63:16] = '1;
        if (sz == 2'd2) v[63:32] = '1;
        return v;
    endfunction

    task automatic run(input logic [31:0] insn, input logic [31:0] base,
                       input logic [63:0] data, input int delay);
        logic [31:0] ea;
        logic [2:0]  f3;
        bit          ill, mis;
        logic [3:0]  code;
        f3  = insn[14:12];
        ea  = base + {{20{insn[31]}}, insn[31:20]};
        ill = (insn[6:0] != 7'b0000111) || !(f3 inside {3'b001, 3'b010, 3'b011});
        mis = !ill && ((ea[2:0] & ((3'd1 << f3[1:0]) - 3'd1)) != 3'd0);
        code = ill ? 4'd2 : 4'd4;
        @(negedge clk);
        issue_valid_i = 1'b1;
        issue_insn_i  = insn;
        base_val_i    = base;
        #1;
        chk(base_idx_o == insn[19:15], "R1", "base index", 64'(base_idx_o), 64'(insn[19:15]));
        @(negedge clk);
        issue_valid_i = 1'b0;
        if (ill || mis) begin
            chk(exc_valid_o && exc_code_o == code, ill ? "R6" : "R5", "exception code",
                64'({exc_valid_o, exc_code_o}), 64'({1'b1, code}));
            chk(!mem_req_o && !fpr_we_o, "R4", "no request on exception",
                64'({mem_req_o, fpr_we_o}), 64'd0);
            @(negedge clk);
            chk(!mem_req_o && !fpr_we_o && ready_o, "R5", "quiet after exception",
                64'({mem_req_o, fpr_we_o, ready_o}), 64'd1);
            return;
        end
        chk(mem_req_o && mem_addr_o == ea, "R2", "request address",
            64'({mem_req_o, mem_addr_o}), 64'({1'b1, ea}));
        chk(mem_size_o == f3[1:0], "R3", "request size", 64'(mem_size_o), 64'(f3[1:0]));
        chk(!ready_o && !exc_valid_o, "R11", "busy after accept",
            64'({ready_o, exc_valid_o}), 64'd0);
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            chk(!mem_req_o && !fpr_we_o && !ready_o, "R4", "single request while waiting",
                64'({mem_req_o, fpr_we_o, ready_o}), 64'd0);
        end
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = data;
        @(negedge clk);
        mem_rvalid_i = 1'b0;
        mem_rdata_i  = '0;
        chk(fpr_we_o && fs_dirty_o && ready_o, "R10", "write and dirty pulse",
            64'({fpr_we_o, fs_dirty_o, ready_o}), 64'd7);
        chk(fpr_idx_o == insn[11:7], "R1", "dest index", 64'(fpr_idx_o), 64'(insn[11:7]));
        chk(fpr_wdata_o == box(f3[1:0], data),
            f3 == 3'b001 ? "R7" : (f3 == 3'b010 ? "R8" : "R9"), "write data",
            fpr_wdata_o, box(f3[1:0], data));
        @(negedge clk);
        chk(!fpr_we_o && !fs_dirty_o, "R10", "write is one pulse",
            64'({fpr_we_o, fs_dirty_o}), 64'd0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        chk(ready_o && !mem_req_o && !fpr_we_o && !fs_dirty_o && !exc_valid_o, "R12",
            "reset outputs", 64'({ready_o, mem_req_o, fpr_we_o, fs_dirty_o, exc_valid_o}),
            64'h10);
        rst_n = 1'b1;
        // directed corner cases
        run(mk(12'h010, 5'd3, 3'b010, 5'd7, 7'b0000111), 32'h1000,
            64'hDEAD_BEEF_7F80_0001, 0);                                    // R8 payload kept
        run(mk(12'h002, 5'd4, 3'b001, 5'd8, 7'b0000111), 32'h2000,
            64'h1234_5678_9ABC_7C01, 2);                                    // R7
        run(mk(12'hFF8, 5'd5, 3'b011, 5'd9, 7'b0000111), 32'h3000,
            64'hFFF0_0000_0000_0001, 1);                                    // R9 negative imm
        run(mk(12'h000, 5'd1, 3'b000, 5'd2, 7'b0000111), 32'h4000, '0, 0); // R6 byte width
        run(mk(12'h000, 5'd1, 3'b100, 5'd2, 7'b0000111), 32'h4000, '0, 0); // R6 funct3 100
        run(mk(12'h001, 5'd1, 3'b010, 5'd2, 7'b0000011), 32'h4000, '0, 0); // R6 over R5
        run(mk(12'h002, 5'd1, 3'b010, 5'd2, 7'b0000111), 32'h4000, '0, 0); // R5 word
        run(mk(12'h004, 5'd1, 3'b011, 5'd2, 7'b0000111), 32'h4000, '0, 0); // R5 double
        run(mk(12'h001, 5'd1, 3'b001, 5'd2, 7'b0000111), 32'h4000, '0, 0); // R5 half
        // constrained random
        for (int n = 0; n < 300; n++) begin
            logic [2:0]  f3;
            logic [6:0]  opc;
            logic [11:0] imm;
            logic [31:0] base, ea;
            f3   = ($urandom % 8 < 6) ? 3'($urandom % 3 + 1) : 3'($urandom);
            opc  = ($urandom % 16 == 0) ? 7'($urandom) : 7'b0000111;
            imm  = 12'($urandom);
            base = $urandom;
            ea   = base + {{20{imm[11]}}, imm};
            if ($urandom % 4 != 0) base = base - {29'd0, ea[2:0]};
            run(mk(imm, 5'($urandom), f3, 5'($urandom), opc), base,
                {$urandom, $urandom}, int'($urandom % 4));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule